// File: doc/BRIEF.md
# Logarithmic-Step Parallel Prefix Scanner

This block takes a vector of N unsigned elements, N a power of two, and returns its inclusive scan under one associative operator. A scan runs in log2(N) clock rounds. In round j every element is combined with the element 2^j places away, and all elements read the values that held before the round. The block then leaves the result on its output port and pulses a completion flag for one cycle.

The operator can be chosen for each scan through a 3-bit select: wrapping sum, maximum, minimum, bitwise AND, OR or XOR. A build parameter can instead fix the operator at elaboration. A direction input chooses a prefix scan, where element i gathers everything at or below i, or a suffix scan, where element i gathers everything at or above i. The lower-index operand is always placed on the left of the operator.

Top module: `prefixScanner`

## Requirements
- R1: A start pulse seen while no scan is in progress is accepted. The completion flag then goes high for exactly one cycle, log2(N) clock edges after the accepting edge, and is low at all other times.
- R2: With the direction input at 0 (prefix), output element i (bits i*W+W-1 .. i*W) holds x0 op x1 op ... op xi when the completion flag is high, where x is the input vector captured at the accepting edge.
- R3: With the direction input at 1 (suffix), output element i holds xi op x(i+1) op ... op x(N-1) when the completion flag is high.
- R4: Operator codes on unsigned data: 0 is sum modulo 2^W, 1 is maximum, 2 is minimum, 3 is bitwise AND, 4 is bitwise OR, 5 is bitwise XOR. The code and the direction are captured at the accepting edge.
- R5: Operator codes 6 and 7 leave every element unchanged, so the result equals the captured input.
- R6: A start pulse that arrives while rounds are in progress is ignored. The running scan keeps its input, its operator and its completion timing.
- R7: The output vector does not change from the completion cycle until the next accepted start.
- R8: During reset the output vector is all zeros and the completion flag is low.
- R9: Through every round of a prefix scan, element 0 keeps its captured value. Through every round of a suffix scan, element N-1 keeps its captured value.
- R10: When the fixed-operator parameter is set, the operator select input has no effect and the parameter's code is used instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request to capture inputs and begin a scan |
| dirSuffix | input | 1 | 0 selects a prefix scan, 1 selects a suffix scan |
| opSel | input | 3 | Operator code (see R4, R5) |
| inVec | input | NUM_ELEMS*ELEM_W | Packed input elements, element 0 in the low bits |
| outVec | output | NUM_ELEMS*ELEM_W | Packed working and result elements |
| donePulse | output | 1 | One-cycle flag that the result is ready |

## Verification
Every operator code, including the two unused ones, is run in both directions over several vectors. The vectors are a ramp, which tells a prefix apart from a suffix and gives sums that wrap; all ones, which saturates AND and cancels XOR; alternating high and low values, which separates maximum from minimum; and a scrambled pattern, which exposes a wrong stride or a swapped neighbour. A start pulse sent in the middle of a scan, together with a hold interval after completion, shows that stray starts are ignored and that the result stays on the output. A second instance with a fixed XOR operator, driven with the sum code, shows that the select input is bypassed.

// File: rtl/prefixScanPkg.sv
package prefixScanPkg;

  localparam int ROUND_IDX_W = 5;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_MAX = 3'd1;
  localparam logic [2:0] OP_MIN = 3'd2;
  localparam logic [2:0] OP_AND = 3'd3;
  localparam logic [2:0] OP_OR  = 3'd4;
  localparam logic [2:0] OP_XOR = 3'd5;

  typedef struct packed {
    logic                   load;
    logic                   step;
    logic [ROUND_IDX_W-1:0] roundIdx;
  } scanStrobes_t;

endpackage

// File: rtl/scanCombine.sv
module scanCombine #(
  parameter int ELEM_W = 8
) (
  input  logic [ELEM_W-1:0] leftOp,
  input  logic [ELEM_W-1:0] rightOp,
  input  logic [2:0]        opCode,
  output logic [ELEM_W-1:0] result
);
  import prefixScanPkg::*;

  always_comb begin
    case (opCode)
      OP_ADD:  result = leftOp + rightOp;
      OP_MAX:  result = (leftOp > rightOp) ? leftOp : rightOp;
      OP_MIN:  result = (leftOp < rightOp) ? leftOp : rightOp;
      OP_AND:  result = leftOp & rightOp;
      OP_OR:   result = leftOp | rightOp;
      OP_XOR:  result = leftOp ^ rightOp;
      default: result = rightOp;
    endcase
  end
endmodule

// File: rtl/prefixScanCtrl.sv
module prefixScanCtrl #(
  parameter int ROUNDS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startPulse,
  output prefixScanPkg::scanStrobes_t strobes,
  output logic                        donePulse
);
  import prefixScanPkg::*;

  typedef enum logic {ST_IDLE, ST_ROUND} ctrlState_t;

  localparam logic [ROUND_IDX_W-1:0] LAST_ROUND = ROUND_IDX_W'(ROUNDS - 1);

  ctrlState_t             state;
  logic [ROUND_IDX_W-1:0] roundCnt;
  logic                   doneReg;
  logic                   acceptStart;

  assign acceptStart = startPulse && (state == ST_IDLE);

  always_comb begin
    strobes.load     = acceptStart;
    strobes.step     = (state == ST_ROUND);
    strobes.roundIdx = roundCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      roundCnt <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (acceptStart) begin
        state    <= ST_ROUND;
        roundCnt <= '0;
      end else if (state == ST_ROUND) begin
        if (roundCnt == LAST_ROUND) begin
          state    <= ST_IDLE;
          roundCnt <= '0;
          doneReg  <= 1'b1;
        end else begin
          roundCnt <= roundCnt + 1'b1;
        end
      end
    end
  end

  assign donePulse = doneReg;
endmodule

// File: rtl/prefixScanDatapath.sv
module prefixScanDatapath #(
  parameter int NUM_ELEMS = 8,
  parameter int ELEM_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  prefixScanPkg::scanStrobes_t   strobes,
  input  logic [2:0]                    opIn,
  input  logic                          dirIn,
  input  logic [NUM_ELEMS*ELEM_W-1:0]   inVec,
  output logic [NUM_ELEMS*ELEM_W-1:0]   outVec
);
  import prefixScanPkg::*;

  localparam int IDX_W = $clog2(NUM_ELEMS);

  logic [ELEM_W-1:0] elems    [NUM_ELEMS];
  logic [ELEM_W-1:0] nextElem [NUM_ELEMS];
  logic [2:0]        opReg;
  logic              dirReg;
  logic [IDX_W:0]    stride;
  logic              opValid;

  assign stride  = (IDX_W + 1)'(1) << strobes.roundIdx;
  assign opValid = (opReg <= OP_XOR);

  for (genvar i = 0; i < NUM_ELEMS; i++) begin : g_elem
    logic              hasPartner;
    logic [IDX_W-1:0]  pSel;
    logic [ELEM_W-1:0] partnerVal;
    logic [ELEM_W-1:0] leftV;
    logic [ELEM_W-1:0] rightV;
    logic [ELEM_W-1:0] combined;

    always_comb begin
      hasPartner = 1'b0;
      pSel       = '0;
      if (!dirReg) begin
        if (i >= int'(stride)) begin
          hasPartner = 1'b1;
          pSel       = IDX_W'(i - int'(stride));
        end
      end else begin
        if (i + int'(stride) < NUM_ELEMS) begin
          hasPartner = 1'b1;
          pSel       = IDX_W'(i + int'(stride));
        end
      end
      partnerVal = elems[pSel];
      leftV      = dirReg ? elems[i] : partnerVal;
      rightV     = dirReg ? partnerVal : elems[i];
    end

    scanCombine #(.ELEM_W(ELEM_W)) u_comb (
      .leftOp (leftV),
      .rightOp(rightV),
      .opCode (opReg),
      .result (combined)
    );

    assign nextElem[i] = (hasPartner && opValid) ? combined : elems[i];
    assign outVec[i*ELEM_W +: ELEM_W] = elems[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_ELEMS; k++) elems[k] <= '0;
      opReg  <= '0;
      dirReg <= 1'b0;
    end else if (strobes.load) begin
      for (int k = 0; k < NUM_ELEMS; k++) elems[k] <= inVec[k*ELEM_W +: ELEM_W];
      opReg  <= opIn;
      dirReg <= dirIn;
    end else if (strobes.step) begin
      for (int k = 0; k < NUM_ELEMS; k++) elems[k] <= nextElem[k];
    end
  end
endmodule

// File: rtl/prefixScanner.sv
module prefixScanner #(
  parameter int NUM_ELEMS    = 8,
  parameter int ELEM_W       = 8,
  parameter bit USE_FIXED_OP = 1'b0,
  parameter int FIXED_OP     = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startPulse,
  input  logic                        dirSuffix,
  input  logic [2:0]                  opSel,
  input  logic [NUM_ELEMS*ELEM_W-1:0] inVec,
  output logic [NUM_ELEMS*ELEM_W-1:0] outVec,
  output logic                        donePulse
);
  import prefixScanPkg::*;

  localparam int ROUNDS = $clog2(NUM_ELEMS);

  scanStrobes_t strobes;
  logic [2:0]   opEff;

  if (USE_FIXED_OP) begin : g_fixedOp
    assign opEff = 3'(FIXED_OP);
  end else begin : g_runtimeOp
    assign opEff = opSel;
  end

  prefixScanCtrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .strobes   (strobes),
    .donePulse (donePulse)
  );

  prefixScanDatapath #(.NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opIn   (opEff),
    .dirIn  (dirSuffix),
    .inVec  (inVec),
    .outVec (outVec)
  );
endmodule

// File: rtl/prefixScanChecker.sv
module prefixScanChecker #(
  parameter int NUM_ELEMS = 8,
  parameter int ELEM_W    = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        startPulse,
  input logic                        dirSuffix,
  input logic [NUM_ELEMS*ELEM_W-1:0] outVec,
  input logic                        donePulse
);
  localparam int ROUNDS = $clog2(NUM_ELEMS);
  localparam logic [7:0] LAST = 8'(ROUNDS);

  logic       cBusy;
  logic [7:0] cCnt;
  logic       cDir;
  logic       cFinal;
  logic       cAccept;

  assign cFinal  = cBusy && (cCnt == LAST);
  assign cAccept = startPulse && (!cBusy || cFinal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cBusy <= 1'b0;
      cCnt  <= '0;
      cDir  <= 1'b0;
    end else if (cAccept) begin
      cBusy <= 1'b1;
      cCnt  <= '0;
      cDir  <= dirSuffix;
    end else if (cFinal) begin
      cBusy <= 1'b0;
      cCnt  <= '0;
    end else if (cBusy) begin
      cCnt <= cCnt + 1'b1;
    end
  end

  // R1: completion flag exactly when the independent round count reaches its end
  a_r1_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    donePulse == cFinal);

  // R1: completion flag lasts a single cycle
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R9: anchor element of a prefix scan never moves during rounds
  a_r9_prefix_anchor: assert property (@(posedge clk) disable iff (!rstN)
    (cBusy && (cCnt < LAST) && !cDir) |=> $stable(outVec[ELEM_W-1:0]));

  // R9: anchor element of a suffix scan never moves during rounds
  a_r9_suffix_anchor: assert property (@(posedge clk) disable iff (!rstN)
    (cBusy && (cCnt < LAST) && cDir) |=> $stable(outVec[NUM_ELEMS*ELEM_W-1 -: ELEM_W]));

  // R7: output held while idle and no start arrives
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((!cBusy || cFinal) && !startPulse) |=> $stable(outVec));
endmodule

bind prefixScanner prefixScanChecker #(.NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .dirSuffix (dirSuffix),
  .outVec    (outVec),
  .donePulse (donePulse)
);

// File: tb/prefixScanner_tb.sv
`timescale 1ns/1ps
module prefixScanner_tb;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int VW = N * W;
  localparam int ROUNDS = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          dirSuffix = 1'b0;
  logic [2:0]    opSel = 3'd0;
  logic [VW-1:0] inVec = '0;
  logic [VW-1:0] outVec;
  logic          donePulse;

  logic          fixStart = 1'b0;
  logic [VW-1:0] fixOut;
  logic          fixDone;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  prefixScanner #(.NUM_ELEMS(N), .ELEM_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .dirSuffix(dirSuffix),
    .opSel(opSel), .inVec(inVec), .outVec(outVec), .donePulse(donePulse)
  );

  prefixScanner #(.NUM_ELEMS(N), .ELEM_W(W), .USE_FIXED_OP(1'b1), .FIXED_OP(5)) u_fix (
    .clk(clk), .rstN(rstN), .startPulse(fixStart), .dirSuffix(1'b0),
    .opSel(3'd0), .inVec(inVec), .outVec(fixOut), .donePulse(fixDone)
  );

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] applyOp(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      3'd0: return W'((int'(a) + int'(b)) % 256);
      3'd1: return (a > b) ? a : b;
      3'd2: return (a < b) ? a : b;
      3'd3: return a & b;
      3'd4: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [VW-1:0] model(input logic [2:0] op, input logic dir, input logic [VW-1:0] v);
    logic [VW-1:0] r;
    logic [W-1:0]  acc;
    r = v;
    if (op > 3'd5) return r;
    if (!dir) begin
      acc = v[W-1:0];
      for (int i = 1; i < N; i++) begin
        acc = applyOp(op, acc, v[i*W +: W]);
        r[i*W +: W] = acc;
      end
    end else begin
      acc = v[(N-1)*W +: W];
      for (int i = N - 2; i >= 0; i--) begin
        acc = applyOp(op, v[i*W +: W], acc);
        r[i*W +: W] = acc;
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] pattern(input int p);
    logic [VW-1:0] v;
    for (int i = 0; i < N; i++) begin
      case (p)
        0: v[i*W +: W] = W'(i * 37 + 200);
        1: v[i*W +: W] = 8'hFF;
        2: v[i*W +: W] = (i % 2 == 0) ? 8'hC3 : 8'h18;
        default: v[i*W +: W] = W'((i * 113 + 71) ^ (i << 5) ^ 90);
      endcase
    end
    return v;
  endfunction

  task automatic runScan(input logic [2:0] op, input logic dir, input logic [VW-1:0] v, input string tag);
    int waited;
    @(negedge clk);
    startPulse = 1'b1; opSel = op; dirSuffix = dir; inVec = v;
    @(negedge clk);
    startPulse = 1'b0;
    waited = 0;
    while (!donePulse && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check({"R1 done latency ", tag}, VW'(waited), VW'(ROUNDS));
    check(tag, outVec, model(op, dir, v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] held;
    int waited;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset outVec", outVec, '0);
    check("R8 reset done", VW'(donePulse), '0);
    rstN = 1'b1;

    // R2 R3 R4 R5: sweep operators, directions and patterns
    for (int op = 0; op < 8; op++) begin
      for (int d = 0; d < 2; d++) begin
        for (int p = 0; p < 4; p++) begin
          string tag;
          if (op > 5) tag = "R5 unused code";
          else if (d == 0) tag = "R2 R4 prefix";
          else tag = "R3 R4 suffix";
          runScan(3'(op), d[0], pattern(p), tag);
        end
      end
    end

    // R6: start during rounds is ignored
    @(negedge clk);
    startPulse = 1'b1; opSel = 3'd0; dirSuffix = 1'b0; inVec = pattern(0);
    @(negedge clk);
    opSel = 3'd4; dirSuffix = 1'b1; inVec = pattern(3);
    @(negedge clk);
    startPulse = 1'b0;
    waited = 1;
    while (!donePulse && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check("R6 done latency with stray start", VW'(waited), VW'(ROUNDS));
    check("R6 result unaffected by stray start", outVec, model(3'd0, 1'b0, pattern(0)));

    // R7: result held after completion
    held = outVec;
    inVec = pattern(2);
    repeat (5) @(negedge clk);
    check("R7 result held", outVec, held);
    check("R1 done low after pulse", VW'(donePulse), '0);

    // R10: fixed XOR operator ignores opSel (tied to sum code)
    @(negedge clk);
    fixStart = 1'b1; inVec = pattern(3);
    @(negedge clk);
    fixStart = 1'b0;
    repeat (ROUNDS) @(negedge clk);
    check("R10 fixed op done", VW'(fixDone), VW'(1));
    check("R10 fixed op result", fixOut, model(3'd5, 1'b0, pattern(3)));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule